// File: doc/BRIEF.md
# Programmable CPU Clock Generator

This block produces the two-phase processor clock (PHI2) for a small computer from a fast master clock. In free-run mode PHI2 is the master clock divided by 2(N+1), where N is a divisor setting. With the default 7-bit setting, N runs from 0 to 127. At N = 0 PHI2 runs at half the master rate. Beside free-running, the clock can be stopped, advanced by exactly one period on a step command, or driven directly from a level input. The level input is used while a boot image is placed into memory cycle by cycle.

PHI2 leaves a flop in every mode, so mode changes never produce runt pulses in free-run, stop or step. A stop request is honoured only while PHI2 is low, so the processor always halts in the low phase. A new divisor takes effect at the next rising edge of PHI2, which is where a period begins. A three-bit status word reports whether the clock is free-running, whether manual mode is on, and the present PHI2 level.

Top module: `cpu_clk_gen`

## Requirements
- R1: While reset is asserted and after it is released with all controls low, PHI2 is low and the status word is zero.
- R2: With run high, starting from stopped with PHI2 low, PHI2 rises on the first clock after run is sampled. After that, each high phase and each low phase lasts exactly N+1 master clocks.
- R3: Status bit 0 is 1 only while free-running, status bit 1 is 1 only in manual mode, and status bit 2 equals the PHI2 level. Bits 0 and 1 are never both 1.
- R4: A divisor change has no effect on the high and low phases of the current period. It applies from the next rising edge of PHI2.
- R5: Dropping run while PHI2 is low stops the clock at the next master clock and clears status bit 0. Dropping run while PHI2 is high lets the high phase run to its full N+1 clocks, after which PHI2 stays low.
- R6: A one-clock step pulse while stopped with PHI2 low produces exactly one period: N+1 clocks high, N+1 clocks low, then a halt with PHI2 low. Step pulses during that period are ignored.
- R7: While manual enable is high, PHI2 equals the manual level sampled one clock earlier. Manual mode overrides run and step.
- R8: Leaving manual mode with PHI2 high keeps PHI2 high for N+1 further clocks, then PHI2 falls and stays low while run and step are low. Leaving with PHI2 low keeps it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| div_i | input | DIV_W | Divisor setting N |
| run_i | input | 1 | Free-run request, level |
| man_en_i | input | 1 | Manual mode enable |
| man_lvl_i | input | 1 | PHI2 level to follow in manual mode |
| step_i | input | 1 | Single-period request, one-clock pulse |
| phi_o | output | 1 | Generated PHI2 clock |
| status_o | output | 3 | {PHI2 level, manual, free-run} |

## Verification
The hardest cases to reach from the ports are transitions that land partway through a phase. These include a stop request in the middle of a high phase, a divisor written while a period is under way, a step pulse arriving during the step's own low phase, and manual mode released with PHI2 held high. The bench gets there by counting PHI2 samples from a known edge and driving the control change on a chosen sample inside the phase. Every divisor value is swept in free-run, together with the smallest divisors in step mode. The expected phase lengths are computed from N alone.

// File: rtl/ccg_pkg.sv
package ccg_pkg;

  typedef enum logic [1:0] {
    CCG_IDLE = 2'd0,
    CCG_FREE = 2'd1,
    CCG_STEP = 2'd2,
    CCG_MAN  = 2'd3
  } ccg_mode_e;

  localparam int unsigned CCG_STAT_W = 3;
  localparam int unsigned STAT_RUN   = 0;
  localparam int unsigned STAT_MAN   = 1;
  localparam int unsigned STAT_LVL   = 2;

endpackage

// File: rtl/ccg_rst_sync.sv
module ccg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/ccg_half_timer.sv
// Counts master clocks within one PHI2 phase against a latched limit.
module ccg_half_timer #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic             restart_i,  // clear count, latch new limit
  input  logic             wrap_i,     // clear count, keep limit
  input  logic             adv_i,      // count one clock
  output logic             tc_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_q, lim_d;
  logic             cnt_en;

  assign cnt_en = restart_i | wrap_i | adv_i;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (restart_i) begin
      cnt_d = '0;
      lim_d = div_i;
    end else if (wrap_i) begin
      cnt_d = '0;
    end else if (adv_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  assign tc_o = (cnt_q == lim_q);

  // R2: the phase count never passes the latched limit
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q);

  // R2: the controller never asks for another count at terminal count
  a_r2_adv_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !restart_i && !wrap_i) |-> !tc_o);

endmodule

// File: rtl/ccg_mode_fsm.sv
// Mode sequencing and the PHI2 flop.
module ccg_mode_fsm
  import ccg_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      man_en_i,
  input  logic      man_lvl_i,
  input  logic      step_i,
  input  logic      tc_i,
  output logic      restart_o,
  output logic      wrap_o,
  output logic      adv_o,
  output logic      phi_o,
  output ccg_mode_e mode_o
);

  ccg_mode_e mode_q, mode_d;
  logic      phi_q, phi_d;

  always_comb begin
    mode_d    = mode_q;
    phi_d     = phi_q;
    restart_o = 1'b0;
    wrap_o    = 1'b0;
    adv_o     = 1'b0;
    if (man_en_i) begin
      mode_d    = CCG_MAN;
      phi_d     = man_lvl_i;
      restart_o = 1'b1;
    end else begin
      case (mode_q)
        CCG_MAN: begin
          mode_d    = CCG_IDLE;
          restart_o = 1'b1;
        end
        CCG_IDLE: begin
          if (phi_q) begin
            // finish a high phase left over from manual mode
            if (tc_i) begin
              phi_d     = 1'b0;
              restart_o = 1'b1;
            end else begin
              adv_o = 1'b1;
            end
          end else if (run_i) begin
            mode_d    = CCG_FREE;
            phi_d     = 1'b1;
            restart_o = 1'b1;
          end else if (step_i) begin
            mode_d    = CCG_STEP;
            phi_d     = 1'b1;
            restart_o = 1'b1;
          end else begin
            restart_o = 1'b1;
          end
        end
        CCG_FREE: begin
          if (!run_i && !phi_q) begin
            mode_d    = CCG_IDLE;
            restart_o = 1'b1;
          end else if (tc_i) begin
            phi_d = ~phi_q;
            if (phi_q) begin
              wrap_o = 1'b1;
            end else begin
              restart_o = 1'b1;  // rising edge: new period, new divisor
            end
          end else begin
            adv_o = 1'b1;
          end
        end
        CCG_STEP: begin
          if (tc_i) begin
            if (phi_q) begin
              phi_d  = 1'b0;
              wrap_o = 1'b1;
            end else begin
              mode_d    = CCG_IDLE;
              restart_o = 1'b1;
            end
          end else begin
            adv_o = 1'b1;
          end
        end
        default: begin
          mode_d    = CCG_IDLE;
          restart_o = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CCG_IDLE;
      phi_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      phi_q  <= phi_d;
    end
  end

  assign phi_o  = phi_q;
  assign mode_o = mode_q;

  // R5: a high phase in free-run is never cut short
  a_r5_high_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CCG_FREE && phi_q && !tc_i && !man_en_i) |=> phi_q);

  // R6: the low phase of a step never produces a second rising edge
  a_r6_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CCG_STEP && !phi_q && !man_en_i) |=> !phi_q);

endmodule

// File: rtl/cpu_clk_gen.sv
module cpu_clk_gen
  import ccg_pkg::*;
#(
  parameter int unsigned DIV_W      = 7,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [DIV_W-1:0]      div_i,
  input  logic                  run_i,
  input  logic                  man_en_i,
  input  logic                  man_lvl_i,
  input  logic                  step_i,
  output logic                  phi_o,
  output logic [CCG_STAT_W-1:0] status_o
);

  logic      rst_sync_n;
  logic      tc;
  logic      restart;
  logic      wrap;
  logic      adv;
  ccg_mode_e mode;

  ccg_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  ccg_half_timer #(
    .DIV_W (DIV_W)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .div_i     (div_i),
    .restart_i (restart),
    .wrap_i    (wrap),
    .adv_i     (adv),
    .tc_o      (tc)
  );

  ccg_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .run_i     (run_i),
    .man_en_i  (man_en_i),
    .man_lvl_i (man_lvl_i),
    .step_i    (step_i),
    .tc_i      (tc),
    .restart_o (restart),
    .wrap_o    (wrap),
    .adv_o     (adv),
    .phi_o     (phi_o),
    .mode_o    (mode)
  );

  always_comb begin
    status_o           = '0;
    status_o[STAT_RUN] = (mode == CCG_FREE);
    status_o[STAT_MAN] = (mode == CCG_MAN);
    status_o[STAT_LVL] = phi_o;
  end

  // R3: free-run and manual flags are never reported together
  a_r3_modes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    $onehot0(status_o[STAT_MAN:STAT_RUN]));

  // R7: manual mode copies the level one clock later
  a_r7_manual_follow: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    man_en_i |=> (phi_o == $past(man_lvl_i)));

  // R5: once stopped low with no request, PHI2 stays low
  a_r5_idle_stays_low: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (mode == CCG_IDLE && !phi_o && !run_i && !step_i && !man_en_i) |=> !phi_o);

endmodule

// File: tb/cpu_clk_gen_tb.sv
module cpu_clk_gen_tb;

  localparam int DIV_W = 7;
  localparam int NMAX  = (1 << DIV_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] div;
  logic             run;
  logic             man_en;
  logic             man_lvl;
  logic             step;
  logic             phi_o;
  logic [2:0]       status_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cpu_clk_gen #(
    .DIV_W (DIV_W)
  ) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .div_i     (div),
    .run_i     (run),
    .man_en_i  (man_en),
    .man_lvl_i (man_lvl),
    .step_i    (step),
    .phi_o     (phi_o),
    .status_o  (status_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts consecutive samples at the given level, starting with the current one
  task automatic measure(input logic lvl, output int len);
    len = 0;
    while (phi_o === lvl && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic count_rises(input int n, output int rises);
    logic prev;
    rises = 0;
    prev  = phi_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!prev && phi_o) rises++;
      prev = phi_o;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int h;
    int l;
    int r;
    rst_n   = 1'b0;
    div     = '0;
    run     = 1'b0;
    man_en  = 1'b0;
    man_lvl = 1'b0;
    step    = 1'b0;
    tick(3);
    chk(phi_o == 1'b0, "R1 phi in reset", int'(phi_o), 0);
    chk(status_o == 3'b000, "R1 status in reset", int'(status_o), 0);
    rst_n = 1'b1;
    tick(4);
    chk(phi_o == 1'b0, "R1 phi after reset", int'(phi_o), 0);
    chk(status_o == 3'b000, "R1 status after reset", int'(status_o), 0);

    // R2 / R5: every divisor, two high phases and one low phase, stop when low
    for (int n = 0; n <= NMAX; n++) begin
      div = DIV_W'(n);
      run = 1'b1;
      tick(1);
      chk(phi_o == 1'b1, "R2 first rising edge", int'(phi_o), 1);
      if (n == 3) chk(status_o == 3'b101, "R3 status free-run high", int'(status_o), 5);
      measure(1'b1, h);
      chk(h == n + 1, "R2 high phase", h, n + 1);
      if (n == 3) chk(status_o == 3'b001, "R3 status free-run low", int'(status_o), 1);
      measure(1'b0, l);
      chk(l == n + 1, "R2 low phase", l, n + 1);
      measure(1'b1, h);
      chk(h == n + 1, "R2 second high phase", h, n + 1);
      run = 1'b0;
      tick(1);
      chk(status_o == 3'b000, "R5 stop on low", int'(status_o), 0);
      tick(2);
    end

    // R4: divisor written during a high phase
    div = 7'd3;
    run = 1'b1;
    tick(1);
    div = 7'd6;
    measure(1'b1, h);
    chk(h == 4, "R4 current high keeps old N", h, 4);
    measure(1'b0, l);
    chk(l == 4, "R4 current low keeps old N", l, 4);
    measure(1'b1, h);
    chk(h == 7, "R4 next high uses new N", h, 7);
    measure(1'b0, l);
    chk(l == 7, "R4 next low uses new N", l, 7);

    // R5: stop requested on the third sample of a high phase
    tick(2);
    run = 1'b0;
    measure(1'b1, h);
    chk(h == 5, "R5 high phase completes", h, 5);
    count_rises(40, r);
    chk(r == 0, "R5 no edge after stop", r, 0);
    chk(phi_o == 1'b0, "R5 halted low", int'(phi_o), 0);
    chk(status_o == 3'b000, "R5 status after stop", int'(status_o), 0);

    // R5: stop requested inside a low phase
    div = 7'd9;
    run = 1'b1;
    tick(1);
    measure(1'b1, h);
    chk(h == 10, "R2 high phase N=9", h, 10);
    tick(2);
    run = 1'b0;
    tick(1);
    chk(status_o == 3'b000, "R5 stop mid low", int'(status_o), 0);
    count_rises(40, r);
    chk(r == 0, "R5 no edge after mid-low stop", r, 0);

    // R6: single step for small divisors, extra pulse in the low phase ignored
    for (int n = 0; n < 8; n++) begin
      div  = DIV_W'(n);
      step = 1'b1;
      tick(1);
      step = 1'b0;
      chk(phi_o == 1'b1, "R6 step rises", int'(phi_o), 1);
      chk(status_o == 3'b100, "R3 status during step", int'(status_o), 4);
      measure(1'b1, h);
      chk(h == n + 1, "R6 step high phase", h, n + 1);
      step = 1'b1;
      tick(1);
      step = 1'b0;
      count_rises(4 * n + 10, r);
      chk(r == 0, "R6 single period only", r, 0);
      chk(phi_o == 1'b0, "R6 halted low", int'(phi_o), 0);
    end

    // R7: manual level pattern, with run and step also active
    div     = 7'd2;
    run     = 1'b1;
    man_en  = 1'b1;
    man_lvl = 1'b0;
    tick(1);
    chk(status_o[1:0] == 2'b10, "R7 manual overrides run", int'(status_o), 2);
    for (int i = 0; i < 16; i++) begin
      logic lvl;
      lvl     = 1'((16'hB2C5 >> i) & 1);
      man_lvl = lvl;
      step    = 1'(i & 1);
      tick(1);
      chk(phi_o == lvl, "R7 manual follows level", int'(phi_o), int'(lvl));
    end
    step = 1'b0;
    run  = 1'b0;

    // R8: leave manual with PHI2 high
    man_lvl = 1'b1;
    div     = 7'd4;
    tick(1);
    chk(phi_o == 1'b1, "R7 manual high", int'(phi_o), 1);
    chk(status_o == 3'b110, "R3 status manual high", int'(status_o), 6);
    man_en = 1'b0;
    tick(1);
    measure(1'b1, h);
    chk(h == 5, "R8 drain high phase", h, 5);
    count_rises(30, r);
    chk(r == 0, "R8 stays low after drain", r, 0);
    chk(status_o == 3'b000, "R8 status after drain", int'(status_o), 0);

    // R8: leave manual with PHI2 low
    man_en  = 1'b1;
    man_lvl = 1'b0;
    tick(2);
    man_en = 1'b0;
    tick(1);
    chk(phi_o == 1'b0, "R8 exit low", int'(phi_o), 0);
    count_rises(20, r);
    chk(r == 0, "R8 no edge after low exit", r, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule